// File: doc/BRIEF.md
# Fractional M/N:D Root Clock Generator

This block produces a derived clock for a downstream consumer. Everything runs in one fast reference clock domain. Each candidate source arrives as a one-cycle enable pulse train, `src_en`. A source-select mux picks one of them. A pre-divider follows, with half-step ratios. An optional fractional M/N:D counter stage comes last. It turns every N pre-divided ticks into M output pulses and also drives a level output whose duty cycle is set by a D value. The result is `clk_en_o`, a clock-enable pulse train, together with `clk_lvl_o`, the duty-shaped level.

Software programs the block through a small word-addressed register port. The addresses are: 0 is the configuration word, 1 is M, 2 is the encoded N, 3 is the encoded D, and 4 is the command word. The configuration word holds three fields. The pre-divider field is in bits [4:0]. The source select is in bits [10:8]. The mode is in bits [13:12], and the value 2'b10 selects dual-edge (M/N:D) mode. Register writes go to shadow copies, and the running settings do not change. Setting bit 0 of the command word requests a commit.

A three-state controller tracks the commit:
- ST_RUN is normal operation. A command write with bit 0 set takes it to ST_PEND.
- ST_PEND waits for the next output pulse, which marks a period boundary, and then moves to ST_LOAD.
- ST_LOAD copies the shadows into the active settings, clears both counters, and returns to ST_RUN.

Top module: `mnd_root_gen`

## Requirements
- R1: During and after reset, the update bit reads 0 and the configuration word reads 0x0000_0001. The active settings are source 0, divider field 1, bypass mode. With the source pulsing every cycle, `clk_en_o` then pulses every cycle after reset.
- R2: The source field in configuration bits [10:8] selects which `src_en` bit feeds the pre-divider. A value of NSRC or more selects no source.
- R3: A pre-divider field value f in bits [4:0] divides by (f+1)/2. The value 0 is treated as 1. After a commit, the first T selected source ticks yield exactly floor(2T/(f+1)) pre-divided ticks.
- R4: In dual-edge mode (bits [13:12] = 2'b10) with M nonzero, the first P pre-divided ticks after a commit yield exactly floor(M·P/N) output pulses. Address 2 holds ~(N−M) masked to W bits, so N = ~reg + M.
- R5: When M is zero, or the mode field is not 2'b10, the M/N:D stage is bypassed and every pre-divided tick is an output pulse.
- R6: In dual-edge mode, `clk_lvl_o` is high while 4·acc < D2, where acc is the M/N:D accumulator. Address 3 holds ~D2 masked to W bits. D2 = 2N gives 50% duty. Outside dual-edge mode, `clk_lvl_o` is low.
- R7: Writes to addresses 0 to 3 do not change the output until a commit.
- R8: Bit 0 of address 4 reads 1 from the command write until the new settings are loaded. Loading happens at the first output pulse after the request, and it clears the counters.
- R9: M, N and D read back masked to W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset |
| src_en | input | NSRC | Source tick enables, one per candidate source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (shadow values, update bit) |
| clk_en_o | output | 1 | Output clock-enable pulse |
| clk_lvl_o | output | 1 | Duty-shaped output level |

## Verification
The bench builds the block with the defaults W=16 and NSRC=4. The 16-bit counter width covers the 75-step and 25-step fractional ratios exactly. It also lets a write of all ones expose the masking at readback.

Four sources are driven: one every cycle, one every second cycle, one every third cycle, and one that never ticks. These make source selection visible as exact pulse counts.

Counts are taken from the first cycle after a commit, when the counters have just been cleared. Every expected value is therefore an exact floor expression rather than a tolerance band.

// File: rtl/mnd_pkg.sv
package mnd_pkg;
    typedef enum logic [1:0] {ST_RUN, ST_PEND, ST_LOAD} upd_state_t;

    typedef struct packed {
        logic [1:0] mode;
        logic [2:0] src;
        logic [4:0] div;
    } root_cfg_t;

    localparam int DIV_LSB  = 0;
    localparam int SRC_LSB  = 8;
    localparam int MODE_LSB = 12;
    localparam logic [1:0] MODE_DUAL = 2'b10;

    localparam logic [2:0] A_CFG = 3'd0;
    localparam logic [2:0] A_M   = 3'd1;
    localparam logic [2:0] A_N   = 3'd2;
    localparam logic [2:0] A_D   = 3'd3;
    localparam logic [2:0] A_CMD = 3'd4;

    localparam root_cfg_t CFG_RESET = '{mode: 2'b00, src: 3'd0, div: 5'd1};
endpackage

// File: rtl/mnd_regs.sv
module mnd_regs
    import mnd_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [2:0]   wr_addr,
    input  logic [31:0]  wr_data,
    input  logic [2:0]   rd_addr,
    input  logic         boundary,
    output logic [31:0]  rd_data,
    output root_cfg_t    act_cfg,
    output logic [W-1:0] act_m,
    output logic [W-1:0] act_n,
    output logic [W-1:0] act_d,
    output logic         loading
);
    root_cfg_t    sh_cfg;
    logic [W-1:0] sh_m, sh_n, sh_d;
    upd_state_t   st, st_nx;
    logic         start;

    assign start   = wr_en && (wr_addr == A_CMD) && wr_data[0];
    assign loading = (st == ST_LOAD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_cfg <= CFG_RESET;
            sh_m   <= '0;
            sh_n   <= '0;
            sh_d   <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                A_CFG: sh_cfg <= '{mode: wr_data[MODE_LSB +: 2],
                                   src:  wr_data[SRC_LSB +: 3],
                                   div:  wr_data[DIV_LSB +: 5]};
                A_M:   sh_m <= wr_data[W-1:0];
                A_N:   sh_n <= wr_data[W-1:0];
                A_D:   sh_d <= wr_data[W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_RUN;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_RUN:  if (start)    st_nx = ST_PEND;
            ST_PEND: if (boundary) st_nx = ST_LOAD;
            ST_LOAD: st_nx = ST_RUN;
            default: st_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_cfg <= CFG_RESET;
            act_m   <= '0;
            act_n   <= '0;
            act_d   <= '0;
        end else if (st == ST_LOAD) begin
            act_cfg <= sh_cfg;
            act_m   <= sh_m;
            act_n   <= sh_n;
            act_d   <= sh_d;
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_CFG: begin
                rd_data[DIV_LSB +: 5]  = sh_cfg.div;
                rd_data[SRC_LSB +: 3]  = sh_cfg.src;
                rd_data[MODE_LSB +: 2] = sh_cfg.mode;
            end
            A_M:   rd_data = 32'(sh_m);
            A_N:   rd_data = 32'(sh_n);
            A_D:   rd_data = 32'(sh_d);
            A_CMD: rd_data[0] = (st != ST_RUN);
            default: rd_data = '0;
        endcase
    end

    AST_PEND_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PEND && !boundary) |=> (st == ST_PEND)); // R8
    AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_LOAD) |=> ($stable(act_cfg) && $stable(act_m) && $stable(act_n) && $stable(act_d))); // R7
endmodule

// File: rtl/mnd_prediv.sv
module mnd_prediv #(
    parameter int DIVW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            tick_in,
    input  logic [DIVW-1:0] div,
    output logic            tick_out
);
    logic [DIVW:0] pacc, thr, sum;

    always_comb begin
        thr = (div == '0) ? (DIVW+1)'(2) : ({1'b0, div} + (DIVW+1)'(1));
        sum = pacc + (DIVW+1)'(2);
        tick_out = !clr && tick_in && (sum >= thr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pacc <= '0;
        else if (clr)     pacc <= '0;
        else if (tick_in) pacc <= (sum >= thr) ? (sum - thr) : sum;
    end

    AST_PACC_BELOW_THR: assert property (@(posedge clk) disable iff (!rst_n)
        (pacc < thr)); // R3
endmodule

// File: rtl/mnd_frac.sv
module mnd_frac #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         on,
    input  logic         tick_in,
    input  logic [W-1:0] m,
    input  logic [W-1:0] n_enc,
    input  logic [W-1:0] d_enc,
    output logic         fire,
    output logic         lvl
);
    logic [W-1:0] acc, nval, d2;
    logic [W:0]   s;

    always_comb begin
        nval = ~n_enc + m;
        d2   = ~d_enc;
        s    = {1'b0, acc} + {1'b0, m};
        fire = on ? (tick_in && (s >= {1'b0, nval})) : tick_in;
        lvl  = on && ({acc, 2'b00} < {2'b00, d2});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              acc <= '0;
        else if (clr)            acc <= '0;
        else if (on && tick_in)  acc <= (s >= {1'b0, nval}) ? W'(s - {1'b0, nval}) : W'(s);
    end

    AST_ACC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (on && m < nval && acc < nval) |=> (acc < $past(nval))); // R4
endmodule

// File: rtl/mnd_root_gen.sv
module mnd_root_gen
    import mnd_pkg::*;
#(
    parameter int W    = 16,
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_en,
    input  logic            wr_en,
    input  logic [2:0]      wr_addr,
    input  logic [31:0]     wr_data,
    input  logic [2:0]      rd_addr,
    output logic [31:0]     rd_data,
    output logic            clk_en_o,
    output logic            clk_lvl_o
);
    root_cfg_t    act_cfg;
    logic [W-1:0] act_m, act_n, act_d;
    logic         loading, sel_tick, pre_tick, fire, lvl, mnd_on;

    mnd_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .boundary(fire),
        .rd_data(rd_data), .act_cfg(act_cfg), .act_m(act_m),
        .act_n(act_n), .act_d(act_d), .loading(loading)
    );

    always_comb begin
        sel_tick = 1'b0;
        for (int i = 0; i < NSRC; i++)
            if (act_cfg.src == 3'(i)) sel_tick = src_en[i];
    end

    assign mnd_on = (act_cfg.mode == MODE_DUAL) && (act_m != '0);

    mnd_prediv #(.DIVW(5)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr(loading), .tick_in(sel_tick),
        .div(act_cfg.div), .tick_out(pre_tick)
    );

    mnd_frac #(.W(W)) u_frac (
        .clk(clk), .rst_n(rst_n), .clr(loading), .on(mnd_on),
        .tick_in(pre_tick), .m(act_m), .n_enc(act_n), .d_enc(act_d),
        .fire(fire), .lvl(lvl)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_en_o  <= 1'b0;
            clk_lvl_o <= 1'b0;
        end else begin
            clk_en_o  <= fire;
            clk_lvl_o <= lvl;
        end
    end

    AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!mnd_on) |=> (clk_en_o == $past(pre_tick))); // R5
    AST_LVL_LOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!mnd_on) |=> !clk_lvl_o); // R6
endmodule

// File: tb/sim_mnd_root_gen.sv
module sim_mnd_root_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src_en = 4'b0001;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        clk_en_o, clk_lvl_o;
    int          n_chk = 0, n_fail = 0, cyc = 0;

    mnd_root_gen #(.W(16), .NSRC(4)) u0 (
        .clk(clk), .rst_n(rst_n), .src_en(src_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .clk_en_o(clk_en_o), .clk_lvl_o(clk_lvl_o)
    );

    always #2.5 clk = ~clk;

    initial forever begin
        @(negedge clk);
        cyc++;
        src_en = {1'b0, (cyc % 3) == 0, cyc[0], 1'b1};
    end

    typedef struct packed {
        logic [3:0]  req;
        logic [2:0]  src;
        logic [4:0]  f;
        logic [1:0]  mode;
        logic [15:0] m, n, d2, t, expv;
        logic        lvl;
    } vec_t;

    localparam vec_t VEC [14] = '{
        '{4'd3, 3'd0, 5'd1, 2'd0, 16'd0,  16'd0,  16'd0,   16'd100, 16'd100, 1'b0}, // R3 div 1
        '{4'd3, 3'd0, 5'd3, 2'd0, 16'd0,  16'd0,  16'd0,   16'd100, 16'd50,  1'b0}, // R3 div 2
        '{4'd3, 3'd0, 5'd2, 2'd0, 16'd0,  16'd0,  16'd0,   16'd100, 16'd66,  1'b0}, // R3 div 1.5
        '{4'd3, 3'd0, 5'd5, 2'd0, 16'd0,  16'd0,  16'd0,   16'd100, 16'd33,  1'b0}, // R3 div 3
        '{4'd2, 3'd1, 5'd1, 2'd0, 16'd0,  16'd0,  16'd0,   16'd100, 16'd50,  1'b0}, // R2 half-rate source
        '{4'd2, 3'd2, 5'd1, 2'd0, 16'd0,  16'd0,  16'd0,   16'd99,  16'd33,  1'b0}, // R2 third-rate source
        '{4'd4, 3'd0, 5'd1, 2'd2, 16'd8,  16'd75, 16'd150, 16'd750, 16'd80,  1'b0}, // R4 8/75
        '{4'd4, 3'd0, 5'd1, 2'd2, 16'd16, 16'd75, 16'd150, 16'd750, 16'd160, 1'b0}, // R4 16/75
        '{4'd4, 3'd0, 5'd3, 2'd2, 16'd4,  16'd25, 16'd50,  16'd200, 16'd16,  1'b0}, // R4 with div 2
        '{4'd5, 3'd0, 5'd1, 2'd2, 16'd0,  16'd25, 16'd50,  16'd100, 16'd100, 1'b0}, // R5 M zero
        '{4'd5, 3'd0, 5'd1, 2'd0, 16'd4,  16'd25, 16'd50,  16'd100, 16'd100, 1'b0}, // R5 mode not dual
        '{4'd6, 3'd0, 5'd1, 2'd2, 16'd1,  16'd4,  16'd8,   16'd400, 16'd200, 1'b1}, // R6 50% duty
        '{4'd6, 3'd0, 5'd1, 2'd2, 16'd1,  16'd4,  16'd2,   16'd400, 16'd100, 1'b1}, // R6 25% duty
        '{4'd6, 3'd0, 5'd1, 2'd2, 16'd1,  16'd4,  16'd12,  16'd400, 16'd300, 1'b1}  // R6 75% duty
    };

    task automatic check(input string req, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic commit();
        int k;
        wr(3'd4, 32'd1);
        rd_addr = 3'd4; #1;
        check("R8 busy after command", int'(rd_data[0]), 1);
        k = 0;
        while (rd_data[0] && k < 2000) begin
            @(negedge clk); #1;
            k++;
        end
        check("R8 busy clears", int'(rd_data[0]), 0);
    endtask

    task automatic count(input int t, input bit use_lvl, output int c);
        c = 0;
        for (int i = 0; i < t; i++) begin
            @(negedge clk);
            c += use_lvl ? int'(clk_lvl_o) : int'(clk_en_o);
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int c;
        repeat (3) @(negedge clk);
        rd_addr = 3'd4; #1;
        check("R1 busy in reset", int'(rd_data[0]), 0);
        check("R1 output in reset", int'(clk_en_o), 0);
        rd_addr = 3'd0; #1;
        check("R1 cfg reset value", int'(rd_data), 1);
        rst_n = 1'b1;
        @(negedge clk);
        count(20, 1'b0, c);
        check("R1 default divide by one", c, 20);

        wr(3'd1, 32'hFFFF_FFFF);
        rd_addr = 3'd1; #1;
        check("R9 M mask", int'(rd_data), 32'h0000_FFFF);
        wr(3'd2, 32'hFFFF_FFFF);
        rd_addr = 3'd2; #1;
        check("R9 N mask", int'(rd_data), 32'h0000_FFFF);

        for (int v = 0; v < 14; v++) begin
            wr(3'd0, {18'd0, VEC[v].mode, 1'b0, VEC[v].src, 3'd0, VEC[v].f});
            wr(3'd1, {16'd0, VEC[v].m});
            wr(3'd2, {16'd0, ~(VEC[v].n - VEC[v].m)});
            wr(3'd3, {16'd0, ~VEC[v].d2});
            commit();
            count(int'(VEC[v].t), VEC[v].lvl, c);
            check($sformatf("R%0d vector %0d", VEC[v].req, v), c, int'(VEC[v].expv));
        end

        // R7: shadow writes leave the running divide-by-one intact
        wr(3'd0, 32'd1); wr(3'd1, 32'd0);
        commit();
        wr(3'd0, 32'd5);
        count(60, 1'b0, c);
        check("R7 uncommitted cfg ignored", c, 60);
        commit();
        count(60, 1'b0, c);
        check("R7 committed divide by three", c, 20);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule